// File: doc/BRIEF.md
# Register Rename Stage with Move Elimination

This block renames one decoded micro-op per cycle. It keeps an alias table that maps 16 architectural registers onto a 32-entry physical register file, and it draws new destinations from a free pool. Full-width register-to-register copies are finished inside the block. The destination is aliased to the physical register that already holds the source, so no execution unit is used. A self-XOR zeroing idiom is finished in the same way. Its destination is pointed at physical register 0, which always reads as zero and is always ready.

Each physical register carries a two-bit share count, a ready bit and a flag meaning "upper half known zero". Elimination is opportunistic. If it is not allowed, the copy is renamed like any other operation and executes normally. Writebacks set ready bits. Retirement of an overwriting mapping hands in the old tag. That tag goes back to the pool once its share count reaches zero.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, architectural register i maps to physical register i+1, and every physical register reads as ready. Physical registers 17 to 31 are free, and nothing is accepted while `in_valid` is low.
- R2: A register-to-register copy (class code 1) of width code 3 (64-bit) is eliminated. `out_elim`=1, `out_pdst` equals the source tag, and no register is allocated. From the next cycle, reads of the destination return that tag and its ready bit.
- R3: Class codes are 0 = ALU, 1 = register copy, 2 = XOR, 3 = copy from memory or immediate. Width codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. An accepted operation that is not eliminated gets the lowest-numbered free physical register, with `out_alloc`=1 and `out_elim`=0. Class 3 and class 0 are never eliminated.
- R4: XOR (class 2) of a register with itself, at width code 2 or 3, is eliminated with `out_pdst`=0. Later reads of that destination return tag 0 as ready.
- R5: XOR of two different registers takes the normal allocating path.
- R6: Copies and self-XOR at width code 0 or 1 are never eliminated.
- R7: A 32-bit copy is eliminated only when the source's physical register holds a zero-extended value. Such a register was last allocated by a 32-bit write, or it is register 0. Otherwise the copy allocates.
- R8: A copy whose source physical register already has a share count of 3 is not eliminated and allocates instead.
- R9: `out_pold` gives the previous mapping of the destination. Retiring a tag lowers its share count by one. At zero the register becomes allocatable from the next cycle. Register 0 is never freed.
- R10: When the pool is empty, an operation that needs a register is not accepted and changes no state. Operations that are eliminated are still accepted.
- R11: A writeback marks its tag ready from the next cycle. A new allocation marks its tag not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Micro-op present |
| in_op | input | 2 | Operation class code |
| in_width | input | 2 | Operand width code |
| in_src_a | input | 4 | First source architectural register |
| in_src_b | input | 4 | Second source architectural register |
| in_dst | input | 4 | Destination architectural register |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | 5 | Physical register written back |
| ret_valid | input | 1 | Retirement strobe |
| ret_tag | input | 5 | Old mapping released by a retiring op |
| out_accept | output | 1 | Micro-op renamed this cycle |
| out_elim | output | 1 | Finished at rename (copy or zeroing) |
| out_alloc | output | 1 | A free register was taken |
| out_psrc_a | output | 5 | Physical tag of first source |
| out_rdy_a | output | 1 | Ready bit of first source |
| out_psrc_b | output | 5 | Physical tag of second source |
| out_rdy_b | output | 1 | Ready bit of second source |
| out_pdst | output | 5 | Physical destination tag |
| out_pold | output | 5 | Previous mapping of the destination |

## Verification
The rename results (`out_accept`, `out_elim`, `out_alloc`, `out_pdst`, `out_pold`) and the source tags and ready bits are combinational. They are due in the same cycle that the micro-op is presented. Alias-table updates, writebacks, retirements and freed registers take effect from the next cycle. The bench drives every input on the falling edge and samples all outputs two nanoseconds later. It then advances its reference model as if the rising edge had happened, so each comparison sees the state left by the previous cycle only.

// File: rtl/rn_pkg.sv
// Shared codes for the rename stage.
// Assumes: class and width codes are fixed by the decoder that feeds the block.
package rn_pkg;
    typedef enum logic [1:0] {
        OP_ALU   = 2'd0,
        OP_MOVRR = 2'd1,
        OP_XOR   = 2'd2,
        OP_MOVMI = 2'd3
    } uop_class_e;

    typedef enum logic [1:0] {
        W_8  = 2'd0,
        W_16 = 2'd1,
        W_32 = 2'd2,
        W_64 = 2'd3
    } width_e;

    localparam int REF_MAX = 3;
    localparam int REF_W   = $clog2(REF_MAX + 1);
endpackage

// File: rtl/rn_free_pool.sv
// Free physical register pool as a bitmap with a lowest-first picker.
// Assumes: register 0 is the zero register and is never handed out;
// registers 1..ARCH_N are the reset mappings.
module rn_free_pool #(
    parameter int ARCH_N = 16,
    parameter int PHYS_N = 32,
    localparam int PW = $clog2(PHYS_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic          release_en,
    input  logic [PW-1:0] release_tag,
    output logic          has_free,
    output logic [PW-1:0] free_tag
);
    logic [PHYS_N-1:0] free_q;

    // Pick the lowest-numbered free register above zero.
    always_comb begin
        has_free = 1'b0;
        free_tag = '0;
        for (int i = PHYS_N - 1; i >= 1; i--) begin
            if (free_q[i]) begin
                has_free = 1'b1;
                free_tag = PW'(i);
            end
        end
    end

    // Take the picked register on allocation and return released ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_N; i++) free_q[i] <= (i > ARCH_N);
        end else begin
            if (alloc_en)   free_q[free_tag]    <= 1'b0;
            if (release_en) free_q[release_tag] <= 1'b1;
        end
    end

    assert_zero_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !free_q[0]);
    assert_no_double_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        release_en |-> !free_q[release_tag]);
endmodule

// File: rtl/rn_ref_track.sv
// Per-physical-register share count, ready bit and zero-extended flag.
// Assumes: increments arrive only when the count is below REF_MAX; a drop
// arrives once per overwritten mapping; tag 0 is never counted.
module rn_ref_track import rn_pkg::*; #(
    parameter int ARCH_N = 16,
    parameter int PHYS_N = 32,
    localparam int PW = $clog2(PHYS_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [PW-1:0] alloc_tag,
    input  logic          alloc_zx,
    input  logic          share_en,
    input  logic [PW-1:0] share_tag,
    input  logic          wb_en,
    input  logic [PW-1:0] wb_tag,
    input  logic          drop_en,
    input  logic [PW-1:0] drop_tag,
    input  logic [PW-1:0] rd_a_tag,
    input  logic [PW-1:0] rd_b_tag,
    output logic          rdy_a,
    output logic          rdy_b,
    output logic          sat_a,
    output logic          zx_a,
    output logic          released
);
    logic [REF_W-1:0] cnt_q [PHYS_N];
    logic [REF_W-1:0] cnt_d [PHYS_N];
    logic             rdy_q [PHYS_N];
    logic             rdy_d [PHYS_N];
    logic             zx_q  [PHYS_N];
    logic             zx_d  [PHYS_N];

    // Read ports for the source lookups.
    assign rdy_a = rdy_q[rd_a_tag];
    assign rdy_b = rdy_q[rd_b_tag];
    assign sat_a = (cnt_q[rd_a_tag] == REF_W'(REF_MAX));
    assign zx_a  = zx_q[rd_a_tag];

    // A drop that takes the last reference frees the register.
    assign released = drop_en && (drop_tag != '0) && (cnt_q[drop_tag] == REF_W'(1))
                      && !(share_en && (share_tag == drop_tag));

    // Next-state of counts, ready bits and zero-extended flags.
    always_comb begin
        cnt_d = cnt_q;
        rdy_d = rdy_q;
        zx_d  = zx_q;
        if (share_en && share_tag != '0) cnt_d[share_tag] = cnt_d[share_tag] + 1'b1;
        if (drop_en && drop_tag != '0)   cnt_d[drop_tag]  = cnt_d[drop_tag] - 1'b1;
        if (wb_en) rdy_d[wb_tag] = 1'b1;
        if (alloc_en) begin
            cnt_d[alloc_tag] = REF_W'(1);
            rdy_d[alloc_tag] = 1'b0;
            zx_d[alloc_tag]  = alloc_zx;
        end
    end

    // Register the per-tag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_N; i++) begin
                cnt_q[i] <= (i >= 1 && i <= ARCH_N) ? REF_W'(1) : '0;
                rdy_q[i] <= 1'b1;
                zx_q[i]  <= (i == 0);
            end
        end else begin
            cnt_q <= cnt_d;
            rdy_q <= rdy_d;
            zx_q  <= zx_d;
        end
    end

    assert_share_below_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        share_en |-> cnt_q[share_tag] != REF_W'(REF_MAX));
    assert_drop_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en && drop_tag != '0) |-> cnt_q[drop_tag] != '0);
endmodule

// File: rtl/rn_classify.sv
// Decides per micro-op whether it is eliminated, zeroed or allocated.
// Assumes: src_sat and src_zx describe the first source's physical register.
module rn_classify import rn_pkg::*; (
    input  logic       valid,
    input  uop_class_e op,
    input  width_e     width,
    input  logic       same_src,
    input  logic       src_sat,
    input  logic       src_zx,
    input  logic       has_free,
    output logic       mov_elim,
    output logic       zero_idiom,
    output logic       elim,
    output logic       accept,
    output logic       alloc
);
    logic wide;

    // Only 32- and 64-bit writes replace the whole register.
    always_comb begin
        wide       = (width == W_32) || (width == W_64);
        zero_idiom = valid && (op == OP_XOR) && same_src && wide;
        mov_elim   = valid && (op == OP_MOVRR) && wide && !src_sat
                     && ((width == W_64) || src_zx);
        elim       = mov_elim || zero_idiom;
        accept     = valid && (elim || has_free);
        alloc      = accept && !elim;
    end
endmodule

// File: rtl/rn_rename_top.sv
// Rename stage: alias table plus free pool and share tracking.
// Renames one micro-op per cycle and finishes full-width register copies
// and self-XOR zeroing without execution.
// Assumes: retire tags are old mappings reported in order, once each.
module rn_rename_top import rn_pkg::*; #(
    parameter int ARCH_N = 16,
    parameter int PHYS_N = 32,
    localparam int AW = $clog2(ARCH_N),
    localparam int PW = $clog2(PHYS_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic [1:0]    in_width,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    input  logic [AW-1:0] in_dst,
    input  logic          wb_valid,
    input  logic [PW-1:0] wb_tag,
    input  logic          ret_valid,
    input  logic [PW-1:0] ret_tag,
    output logic          out_accept,
    output logic          out_elim,
    output logic          out_alloc,
    output logic [PW-1:0] out_psrc_a,
    output logic          out_rdy_a,
    output logic [PW-1:0] out_psrc_b,
    output logic          out_rdy_b,
    output logic [PW-1:0] out_pdst,
    output logic [PW-1:0] out_pold
);
    logic [PW-1:0] rat_q [ARCH_N];
    uop_class_e    op;
    width_e        width;
    logic          has_free, released, sat_a, zx_a;
    logic          mov_elim, zero_idiom;
    logic [PW-1:0] free_tag;

    assign op    = uop_class_e'(in_op);
    assign width = width_e'(in_width);

    // Source and old-destination lookups.
    assign out_psrc_a = rat_q[in_src_a];
    assign out_psrc_b = rat_q[in_src_b];
    assign out_pold   = rat_q[in_dst];

    // Destination tag: zero register, shared source, or a fresh register.
    assign out_pdst = zero_idiom ? '0 : (mov_elim ? out_psrc_a : free_tag);

    rn_classify u_cls (
        .valid(in_valid), .op(op), .width(width),
        .same_src(in_src_a == in_src_b), .src_sat(sat_a), .src_zx(zx_a),
        .has_free(has_free), .mov_elim(mov_elim), .zero_idiom(zero_idiom),
        .elim(out_elim), .accept(out_accept), .alloc(out_alloc)
    );

    rn_free_pool #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) u_pool (
        .clk(clk), .rst_n(rst_n), .alloc_en(out_alloc),
        .release_en(released), .release_tag(ret_tag),
        .has_free(has_free), .free_tag(free_tag)
    );

    rn_ref_track #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) u_ref (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(out_alloc), .alloc_tag(free_tag), .alloc_zx(width == W_32),
        .share_en(mov_elim), .share_tag(out_psrc_a),
        .wb_en(wb_valid), .wb_tag(wb_tag),
        .drop_en(ret_valid), .drop_tag(ret_tag),
        .rd_a_tag(out_psrc_a), .rd_b_tag(out_psrc_b),
        .rdy_a(out_rdy_a), .rdy_b(out_rdy_b), .sat_a(sat_a), .zx_a(zx_a),
        .released(released)
    );

    // Alias table: reset to identity-plus-one, update on every accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_N; i++) rat_q[i] <= PW'(i + 1);
        end else if (out_accept) begin
            rat_q[in_dst] <= out_pdst;
        end
    end

    assert_copy_aliases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_elim && op == OP_MOVRR) |=> rat_q[$past(in_dst)] == $past(out_psrc_a));
    assert_zeroing_maps_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_elim && op == OP_XOR) |=> rat_q[$past(in_dst)] == '0);
    assert_narrow_not_elim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (width == W_8 || width == W_16)) |-> !out_elim);
    assert_stall_keeps_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_accept) |=> rat_q[$past(in_dst)] == $past(out_pold));
endmodule

// File: tb/test_rn_rename_top.sv
module test_rn_rename_top;
    localparam int NA = 16;
    localparam int NP = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_op = '0, in_width = '0;
    logic [3:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic       wb_valid = 1'b0, ret_valid = 1'b0;
    logic [4:0] wb_tag = '0, ret_tag = '0;
    logic       out_accept, out_elim, out_alloc, out_rdy_a, out_rdy_b;
    logic [4:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;

    rn_rename_top i_rn_rename_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_width(in_width), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_dst(in_dst), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .out_accept(out_accept),
        .out_elim(out_elim), .out_alloc(out_alloc), .out_psrc_a(out_psrc_a),
        .out_rdy_a(out_rdy_a), .out_psrc_b(out_psrc_b), .out_rdy_b(out_rdy_b),
        .out_pdst(out_pdst), .out_pold(out_pold)
    );

    always #10 clk = ~clk;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int m_rat[NA];
    int m_cnt[NP], m_rdy[NP], m_zx[NP], m_free[NP];
    int rq[$];
    int wq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int nfree();
        int n = 0;
        for (int i = 1; i < NP; i++) n += m_free[i];
        return n;
    endfunction

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit v, input int op, input int w, input int a, input int b,
                        input int d, input bit wv, input int wt, input bit rv, input int rt);
        int pa, pb, f, pd, po;
        bit wide, zi, mv, el, acc;
        string lbl;
        @(negedge clk);
        in_valid = v; in_op = 2'(op); in_width = 2'(w);
        in_src_a = 4'(a); in_src_b = 4'(b); in_dst = 4'(d);
        wb_valid = wv; wb_tag = 5'(wt); ret_valid = rv; ret_tag = 5'(rt);
        #2;
        pa = m_rat[a]; pb = m_rat[b]; po = m_rat[d];
        wide = (w >= 2);
        zi = (op == 2) && (a == b) && wide;
        mv = (op == 1) && wide && (pa == 0 || m_cnt[pa] < 3) && (w == 3 || m_zx[pa] == 1);
        el = v && (zi || mv);
        f = -1;
        for (int i = NP - 1; i >= 1; i--) if (m_free[i] != 0) f = i;
        acc = v && (el || f >= 0);
        pd = zi ? 0 : (mv ? pa : f);
        if (v && !el && f < 0)                          lbl = "R10";
        else if (zi)                                    lbl = "R4";
        else if (mv)                                    lbl = (w == 2) ? "R7" : "R2";
        else if ((op == 1 || op == 2) && !wide)         lbl = "R6";
        else if (op == 1 && w == 2 && m_zx[pa] == 0)    lbl = "R7";
        else if (op == 1)                               lbl = "R8";
        else if (op == 2)                               lbl = "R5";
        else                                            lbl = "R3";
        check(out_accept === acc, lbl, out_accept, acc);
        if (acc) begin
            check(out_elim === el, lbl, out_elim, el);
            check(out_alloc === !el, "R3", out_alloc, !el);
            check(out_pdst === 5'(pd), lbl, out_pdst, pd);
            check(out_pold === 5'(po), "R9", out_pold, po);
        end
        check(out_psrc_a === 5'(pa), "R2", out_psrc_a, pa);
        check(out_psrc_b === 5'(pb), "R2", out_psrc_b, pb);
        check(out_rdy_a === 1'(m_rdy[pa]), "R11", out_rdy_a, m_rdy[pa]);
        check(out_rdy_b === 1'(m_rdy[pb]), "R11", out_rdy_b, m_rdy[pb]);
        if (wv) m_rdy[wt] = 1;
        if (acc && !el) begin
            m_free[f] = 0; m_cnt[f] = 1; m_rdy[f] = 0; m_zx[f] = (w == 2);
            wq.push_back(f);
        end
        if (acc && mv && pa != 0) m_cnt[pa]++;
        if (acc) begin
            rq.push_back(po);
            m_rat[d] = pd;
        end
        if (rv && rt != 0) begin
            m_cnt[rt]--;
            if (m_cnt[rt] == 0) m_free[rt] = 1;
        end
    endtask

    task automatic idle_retire();
        int t = rq.pop_front();
        step(0, 0, 3, 0, 0, 0, 0, 0, 1, t);
    endtask

    initial begin
        for (int i = 0; i < NA; i++) m_rat[i] = i + 1;
        for (int i = 0; i < NP; i++) begin
            m_cnt[i] = (i >= 1 && i <= NA) ? 1 : 0;
            m_rdy[i] = 1; m_zx[i] = (i == 0); m_free[i] = (i > NA);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset mapping and readiness
        step(0, 0, 3, 3, 15, 0, 0, 0, 0, 0);
        check(out_psrc_a === 5'd4 && out_psrc_b === 5'd16, "R1", out_psrc_a, 4);
        check(out_rdy_a && out_rdy_b && !out_accept, "R1", out_accept, 0);

        // R9: freed register comes back, zero register does not
        step(1, 0, 3, 2, 3, 1, 0, 0, 0, 0);           // r1 -> 17, old 2
        idle_retire();                                 // frees 2
        step(1, 3, 3, 0, 0, 2, 0, 0, 0, 0);           // memory/imm copy allocates
        check(out_pdst === 5'd2 && !out_elim, "R9", out_pdst, 2);
        step(1, 2, 3, 6, 6, 6, 0, 0, 0, 0);           // R4 zeroing
        check(out_elim === 1'b1 && out_pdst === 5'd0, "R4", out_pdst, 0);
        step(1, 0, 3, 6, 6, 0, 0, 0, 0, 0);           // read r6 -> zero reg, ready
        check(out_psrc_a === 5'd0 && out_rdy_a === 1'b1, "R4", out_psrc_a, 0);
        step(1, 0, 3, 1, 1, 6, 0, 0, 0, 0);           // overwrite r6, old 0
        while (rq.size() > 0) idle_retire();
        step(1, 0, 3, 1, 1, 9, 0, 0, 0, 0);
        check(out_pdst !== 5'd0 && out_alloc === 1'b1, "R9", out_pdst, 1);

        // R2: 64-bit copy eliminated, consumer sees source tag
        step(1, 1, 3, 4, 4, 5, 0, 0, 0, 0);
        check(out_elim === 1'b1 && out_pdst === 5'd5, "R2", out_pdst, 5);
        step(0, 0, 3, 5, 4, 0, 0, 0, 0, 0);
        check(out_psrc_a === 5'd5, "R2", out_psrc_a, 5);
        // R5, R6
        step(1, 2, 3, 7, 8, 7, 0, 0, 0, 0);
        check(out_elim === 1'b0 && out_alloc === 1'b1, "R5", out_elim, 0);
        step(1, 1, 1, 9, 9, 10, 0, 0, 0, 0);
        check(out_elim === 1'b0, "R6", out_elim, 0);
        step(1, 2, 0, 11, 11, 11, 0, 0, 0, 0);
        check(out_elim === 1'b0, "R6", out_elim, 0);
        // R7: 32-bit copy needs a zero-extended source
        step(1, 1, 2, 12, 12, 13, 0, 0, 0, 0);
        check(out_elim === 1'b0, "R7", out_elim, 0);
        step(1, 1, 2, 13, 13, 14, 0, 0, 0, 0);
        check(out_elim === 1'b1, "R7", out_elim, 1);
        // R8: share saturation
        step(1, 1, 3, 2, 2, 3, 0, 0, 0, 0);
        step(1, 1, 3, 2, 2, 4, 0, 0, 0, 0);
        step(1, 1, 3, 2, 2, 15, 0, 0, 0, 0);
        check(out_elim === 1'b0 && out_accept === 1'b1, "R8", out_elim, 0);
        // R11: writeback makes the tag ready next cycle
        step(0, 0, 3, 15, 15, 0, 1, m_rat[15], 0, 0);
        step(0, 0, 3, 15, 15, 0, 0, 0, 0, 0);
        check(out_rdy_a === 1'b1, "R11", out_rdy_a, 1);
        // R10: exhaust the pool
        while (nfree() > 0) step(1, 0, 3, 1, 1, 12, 0, 0, 0, 0);
        step(1, 0, 3, 1, 1, 12, 0, 0, 0, 0);
        check(out_accept === 1'b0, "R10", out_accept, 0);
        step(1, 2, 3, 8, 8, 8, 0, 0, 0, 0);
        check(out_accept === 1'b1 && out_elim === 1'b1, "R10", out_accept, 1);

        // Mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int op, w, a, b, d, wt, rt;
            bit wv, rv;
            op = int'($urandom_range(0, 3)); w = int'($urandom_range(0, 3));
            a = int'($urandom_range(0, 7)); d = int'($urandom_range(0, 7));
            b = ($urandom_range(0, 2) == 0) ? a : int'($urandom_range(0, 7));
            wv = (wq.size() > 0) && ($urandom_range(0, 1) == 1);
            wt = wv ? wq.pop_front() : 0;
            rv = (rq.size() > 0) && ($urandom_range(0, 2) != 0);
            rt = rv ? rq.pop_front() : 0;
            step($urandom_range(0, 5) != 0, op, w, a, b, d, wv, wt, rv, rt);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule